// File: doc/BRIEF.md
# Dual-Channel DAC Update Sequencer

This block decides when each of two 16-bit DAC code registers takes a new value. A two-bit mode input selects one of four behaviours. In the first, a host write lands in the addressed channel at once. In the second and third, host writes are parked in per-channel holding registers and copied out together, either on a synchronous software strobe or on an active-low timer trigger pulse. The fourth is a waveform mode, where each trigger pulls samples from an external show-ahead sample FIFO.

The timer trigger is either an external pin or one of four counter outputs, picked by a select bit and a counter index. It passes through a two-flop synchronizer, and only its falling edge acts, so a held-low trigger produces a single update. In waveform mode, a single-update setting reads one FIFO word per pulse and alternates the channels, starting at DAC0. A dual-update setting with both channels on reads two consecutive words, DAC0 first and then DAC1, in back-to-back cycles.

If the FIFO is empty when a read is due, that write is skipped, the DAC keeps its value, the channel pointer stays put, and a sticky underrun flag is raised.

Top module: `dac_update_seq`

## Requirements
- R1: After reset `dac0`, `dac1`, `underrun` and `fifo_rd` are all 0.
- R2: With `upd_mode`=00 (immediate), a cycle with `wr_en` high loads `wr_data` into DAC0 (`wr_ch`=0) or DAC1 (`wr_ch`=1) at that clock edge.
- R3: With `upd_mode`=01 (strobe), host writes only fill the holding registers and leave the DACs unchanged. A cycle with `upd_strobe` high copies both holding registers into both DACs at that edge.
- R4: With `upd_mode`=10 (timer), a high-to-low transition of the selected trigger copies both holding registers into the DACs. This happens at the third rising edge after the low level is first sampled. A trigger held low for any length gives exactly one update.
- R5: `trig_sel`=0 selects `ext_trig_n`. `trig_sel`=1 selects `ctr_n[ctr_pick]`. Pulses on unselected sources have no effect.
- R6: With `upd_mode`=11, `dual_mode`=0 and `ch_en`=11, each trigger reads one FIFO word. The words go to DAC0, DAC1, DAC0 and so on in turn.
- R7: With `upd_mode`=11, `dual_mode`=1 and `ch_en`=11, each trigger reads two words in consecutive cycles. The first goes to DAC0 and the second to DAC1.
- R8: With only one bit of `ch_en` set (bit 0 = DAC0, bit 1 = DAC1), each trigger reads one word into that channel, in either update mode.
- R9: `fifo_rd` is high for one cycle per word taken and only while `fifo_empty` is low. The DAC captures `fifo_data` at the edge ending that cycle.
- R10: A read due while `fifo_empty` is high is skipped. The DAC keeps its value, the alternation pointer does not advance, and `underrun` goes high and stays high until reset.
- R11: Any change of {`upd_mode`, `dual_mode`, `ch_en`} returns the alternation pointer to DAC0 and cancels a pending second read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_mode | input | 2 | 00 immediate, 01 strobe, 10 timer, 11 waveform |
| dual_mode | input | 1 | Waveform: 1 = two reads per trigger |
| ch_en | input | 2 | Channel enables, bit 0 DAC0, bit 1 DAC1 |
| trig_sel | input | 1 | Trigger source: 0 external, 1 counter |
| ctr_pick | input | 2 | Counter index when `trig_sel`=1 |
| ext_trig_n | input | 1 | External active-low trigger |
| ctr_n | input | 4 | Active-low counter outputs |
| wr_en | input | 1 | Host write enable |
| wr_ch | input | 1 | Host write channel |
| wr_data | input | 16 | Host write code |
| upd_strobe | input | 1 | Software update strobe |
| fifo_data | input | 16 | FIFO head word (show-ahead) |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_rd | output | 1 | FIFO pop strobe |
| dac0 | output | 16 | DAC0 code register |
| dac1 | output | 16 | DAC1 code register |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
The assertions rely on two properties of the inputs. First, the FIFO is show-ahead: `fifo_data` holds the head word whenever `fifo_empty` is low, and it changes only after a pop. Second, `upd_strobe` is a synchronous pulse.

The dual-read property also allows for a configuration change landing between the two reads. The stimulus keeps the configuration still while a trigger is in flight. It waits several cycles after each pulse, and it fills the bench FIFO before triggering, so each mid-stream underrun is deliberate.

// File: rtl/dac_update_seq.sv
module dac_update_seq #(
  parameter int DW   = 16,
  parameter int NCTR = 4,
  localparam int CW  = $clog2(NCTR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    upd_mode,
  input  logic          dual_mode,
  input  logic [1:0]    ch_en,
  input  logic          trig_sel,
  input  logic [CW-1:0] ctr_pick,
  input  logic          ext_trig_n,
  input  logic [NCTR-1:0] ctr_n,
  input  logic          wr_en,
  input  logic          wr_ch,
  input  logic [DW-1:0] wr_data,
  input  logic          upd_strobe,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_empty,
  output logic          fifo_rd,
  output logic [DW-1:0] dac0,
  output logic [DW-1:0] dac1,
  output logic          underrun
);
  localparam logic [1:0] M_IMM = 2'b00, M_STB = 2'b01, M_TMR = 2'b10, M_WAVE = 2'b11;

  logic [2:0]    sync;
  logic [4:0]    cfg_q;
  logic          ptr, sec;
  logic [DW-1:0] hold0, hold1;

  wire trig_n   = trig_sel ? ctr_n[ctr_pick] : ext_trig_n;
  wire fall     = sync[2] & ~sync[1];
  wire [4:0] cfg = {upd_mode, dual_mode, ch_en};
  wire chg      = cfg != cfg_q;
  wire wave     = (upd_mode == M_WAVE) && !chg;
  wire both     = ch_en == 2'b11;
  wire slot_due = wave && (sec || (fall && |ch_en));
  wire slot_ch  = sec ? 1'b1 : both ? (dual_mode ? 1'b0 : ptr) : ch_en[1];
  wire load_all = (upd_mode == M_STB && upd_strobe) || (upd_mode == M_TMR && fall);
  wire imm      = (upd_mode == M_IMM) && wr_en;

  assign fifo_rd = slot_due && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '1;
      cfg_q    <= '0;
      ptr      <= 1'b0;
      sec      <= 1'b0;
      underrun <= 1'b0;
      hold0    <= '0;
      hold1    <= '0;
      dac0     <= '0;
      dac1     <= '0;
    end else begin
      sync  <= {sync[1:0], trig_n};
      cfg_q <= cfg;
      if (chg) ptr <= 1'b0;
      else if (fifo_rd && !sec && both && !dual_mode) ptr <= ~ptr;
      sec      <= wave && !sec && fall && dual_mode && both && !fifo_empty;
      underrun <= underrun | (slot_due & fifo_empty);
      if (wr_en && !wr_ch) hold0 <= wr_data;
      if (wr_en &&  wr_ch) hold1 <= wr_data;
      if (load_all)                      dac0 <= hold0;
      else if (imm && !wr_ch)            dac0 <= wr_data;
      else if (fifo_rd && !slot_ch)      dac0 <= fifo_data;
      if (load_all)                      dac1 <= hold1;
      else if (imm && wr_ch)             dac1 <= wr_data;
      else if (fifo_rd && slot_ch)       dac1 <= fifo_data;
    end
  end

  a_r9_rd_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  a_r9_rd_wave_only: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> upd_mode == M_WAVE);
  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  a_r6_single_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !dual_mode) |=> !fifo_rd);
  a_r7_dual_second: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && wave && dual_mode && both && fifo_rd) |=> (fifo_rd || fifo_empty || chg));
  a_r3_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode == M_STB && !upd_strobe) |=> ($stable(dac0) && $stable(dac1)));
endmodule

// File: tb/dac_update_seq_test.sv
module dac_update_seq_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] upd_mode = 0;
  logic dual_mode = 0;
  logic [1:0] ch_en = 2'b11;
  logic trig_sel = 0;
  logic [1:0] ctr_pick = 0;
  logic ext_trig_n = 1;
  logic [3:0] ctr_n = 4'hF;
  logic wr_en = 0, wr_ch = 0;
  logic [15:0] wr_data = 0;
  logic upd_strobe = 0;
  logic [15:0] fifo_data = 0;
  logic fifo_empty = 1;
  wire fifo_rd, underrun;
  wire [15:0] dac0, dac1;

  dac_update_seq uut (.clk, .rst_n, .upd_mode, .dual_mode, .ch_en, .trig_sel, .ctr_pick,
    .ext_trig_n, .ctr_n, .wr_en, .wr_ch, .wr_data, .upd_strobe, .fifo_data, .fifo_empty,
    .fifo_rd, .dac0, .dac1, .underrun);

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [15:0] q[$];
  logic [15:0] m0, m1, hd0, hd1, n0, n1;
  bit mptr, msec, nsec, und, h1 = 1, h2 = 1, h3 = 1, rd, slot, c, fall, chg, rd_seen = 0;
  logic [4:0] pcfg, cfg;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m0 = 0; m1 = 0; hd0 = 0; hd1 = 0; mptr = 0; msec = 0; und = 0;
      h1 = 1; h2 = 1; h3 = 1; pcfg = 0;
    end else begin
      fall = h3 && !h2;
      cfg = {upd_mode, dual_mode, ch_en};
      chg = cfg != pcfg;
      rd = 0; slot = 0; c = 0; nsec = 0; n0 = m0; n1 = m1;
      if (upd_mode == 0 && wr_en) begin if (wr_ch) n1 = wr_data; else n0 = wr_data; end
      if ((upd_mode == 1 && upd_strobe) || (upd_mode == 2 && fall)) begin n0 = hd0; n1 = hd1; end
      if (upd_mode == 3 && !chg) begin
        if (msec) begin slot = 1; c = 1; end
        else if (fall && ch_en != 0) begin
          slot = 1;
          if (ch_en == 3) c = dual_mode ? 1'b0 : mptr; else c = ch_en[1];
        end
      end
      if (slot) begin
        if (fifo_empty) und = 1;
        else begin
          rd = 1;
          void'(q.pop_front());
          if (c) n1 = fifo_data; else n0 = fifo_data;
          if (!msec && ch_en == 3) begin if (dual_mode) nsec = 1; else mptr = !mptr; end
        end
      end
      if (chg) mptr = 0;
      chk({cur_req, "/R9 fifo_rd"}, rd_seen, rd);
      msec = nsec; m0 = n0; m1 = n1;
      if (wr_en) begin if (wr_ch) hd1 = wr_data; else hd0 = wr_data; end
      pcfg = cfg; h3 = h2; h2 = h1;
      h1 = trig_sel ? ctr_n[ctr_pick] : ext_trig_n;
    end
  end

  always @(negedge clk) begin
    fifo_empty = (q.size() == 0);
    fifo_data = fifo_empty ? 16'h0 : q[0];
    #1;
    rd_seen = fifo_rd;
    if (rst_n) begin
      chk({cur_req, " dac0"}, dac0, m0);
      chk({cur_req, " dac1"}, dac1, m1);
      chk({cur_req, " underrun"}, underrun, und);
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(bit ch, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_ch = ch; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse(bit use_ctr, int idx, int lo);
    @(negedge clk);
    if (use_ctr) ctr_n[idx] = 0; else ext_trig_n = 0;
    repeat (lo) @(negedge clk);
    ctr_n = 4'hF; ext_trig_n = 1;
    idle(5);
  endtask
  task automatic look(string r, logic [15:0] e0, logic [15:0] e1);
    @(negedge clk); #2;
    chk({r, " dac0"}, dac0, e0);
    chk({r, " dac1"}, dac1, e1);
  endtask
  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    idle(3);
    #2;
    chk("R1 dac0", dac0, 0); chk("R1 dac1", dac1, 0);
    chk("R1 underrun", underrun, 0); chk("R1 fifo_rd", fifo_rd, 0);
    @(negedge clk); rst_n = 1;
    cur_req = "R2"; upd_mode = 2'b00; idle(2);
    wr(0, 16'h1234); wr(1, 16'hABCD); look("R2", 16'h1234, 16'hABCD);
    cur_req = "R3"; upd_mode = 2'b01; idle(2);
    wr(0, 16'h1111); wr(1, 16'h2222); idle(2); look("R3 held", 16'h1234, 16'hABCD);
    @(negedge clk); upd_strobe = 1; @(negedge clk); upd_strobe = 0;
    look("R3 strobe", 16'h1111, 16'h2222);
    cur_req = "R4"; upd_mode = 2'b10; trig_sel = 0; idle(2);
    wr(0, 16'h3333); wr(1, 16'h4444); pulse(0, 0, 2); look("R4", 16'h3333, 16'h4444);
    wr(0, 16'h5555);
    @(negedge clk); ext_trig_n = 0; idle(5); wr(0, 16'h6666); idle(7); ext_trig_n = 1; idle(5);
    look("R4 one update", 16'h5555, 16'h4444);
    cur_req = "R5"; trig_sel = 1; ctr_pick = 2; wr(0, 16'h7777);
    pulse(1, 1, 2); pulse(0, 0, 2); look("R5 unselected", 16'h5555, 16'h4444);
    pulse(1, 2, 2); look("R5 counter", 16'h7777, 16'h4444);
    cur_req = "R6"; trig_sel = 0; upd_mode = 2'b11; dual_mode = 0; ch_en = 2'b11; idle(2);
    q.push_back(16'hA001); q.push_back(16'hA002); q.push_back(16'hA003); q.push_back(16'hA004);
    idle(2);
    pulse(0, 0, 2); look("R6 first", 16'hA001, 16'h4444);
    pulse(0, 0, 2); look("R6 second", 16'hA001, 16'hA002);
    pulse(0, 0, 2); look("R6 third", 16'hA003, 16'hA002);
    cur_req = "R11"; dual_mode = 1; idle(3); dual_mode = 0; idle(3);
    pulse(0, 0, 2); look("R11 pointer reset", 16'hA004, 16'hA002);
    cur_req = "R7"; dual_mode = 1; idle(2);
    q.push_back(16'hB001); q.push_back(16'hB002); q.push_back(16'hB003); q.push_back(16'hB004);
    idle(2);
    pulse(0, 0, 2); look("R7 pair", 16'hB001, 16'hB002);
    pulse(0, 0, 2); look("R7 pair2", 16'hB003, 16'hB004);
    cur_req = "R8"; ch_en = 2'b10; idle(2);
    q.push_back(16'hC001); q.push_back(16'hC002); idle(2);
    pulse(0, 0, 2); look("R8 dual one ch", 16'hB003, 16'hC001);
    chk("R8 words left", q.size(), 1);
    dual_mode = 0; idle(2);
    pulse(0, 0, 2); look("R8 single one ch", 16'hB003, 16'hC002);
    cur_req = "R10"; ch_en = 2'b01; idle(3);
    pulse(0, 0, 2); look("R10 held", 16'hB003, 16'hC002);
    chk("R10 flag", underrun, 1);
    q.push_back(16'hD001); idle(2);
    pulse(0, 0, 2); look("R10 resume", 16'hD001, 16'hC002);
    chk("R10 sticky", underrun, 1);
    ch_en = 2'b11; idle(3);
    pulse(0, 0, 2);
    q.push_back(16'hE001); idle(2);
    pulse(0, 0, 2); look("R10 pointer held", 16'hE001, 16'hC002);
    idle(3);
    done = 1;
    report();
  end
endmodule